// File: doc/BRIEF.md
# Synchronized DMA Request Router

This block is a single channel of a DMA request router. It picks one peripheral request line out of a parameterized set and presents it to a DMA controller through a request/acknowledge pair. A handshake counts as one forwarded request in any clock cycle where `dma_req_o` and `dma_ack_i` are both high.

The channel has two modes. With synchronization off, the selected request reaches the output combinationally. With synchronization on, the channel holds the request back until it sees a chosen edge on a selected synchronization input. That edge opens a window of NBREQ+1 forwarded requests.

One counter serves three purposes. It closes the window, it raises a one-cycle event pulse when event generation is enabled, and it supports overrun detection. An overrun is a synchronization edge that arrives while a window is still open. It sets a sticky flag, which is cleared by writing one, and the flag can drive an interrupt. The synchronization inputs are assumed to be in the block's clock domain and are registered once to detect edges.

Top module: `sync_req_router`

## Requirements
- R1: After reset, `dma_req_o`, `evt_o`, `ovr_flag_o`, `irq_o` are 0 and `nbreq_o` is 0.
- R2: With `sync_en_i`=0, `dma_req_o` equals `req_i[req_sel_i]` in the same cycle, and activity on `sync_i` has no effect on it.
- R3: With `sync_en_i`=1, `dma_req_o` stays 0 until a qualifying edge on `sync_i[sync_sel_i]`. The edge is sampled at a clock edge, and the request is forwarded from that clock edge on.
- R4: An opened window closes after exactly NBREQ+1 handshakes. Further edges are needed to reopen it.
- R5: When `evt_en_i`=1, the handshake that completes NBREQ+1 forwarded requests is followed in the next cycle by a one-cycle pulse on `evt_o`. This holds in both modes. When `evt_en_i`=0, `evt_o` stays 0.
- R6: `sync_pol_i` encoding: 0 detects nothing, 1 detects rising edges, 2 detects falling edges, 3 detects both.
- R7: A qualifying edge while the window is open and `sync_en_i`=1 sets `ovr_flag_o` after the clock edge. The open window keeps forwarding.
- R8: `ovr_flag_o` holds until a cycle with `ovr_clr_i`=1 clears it. A set in that same cycle wins over the clear. `irq_o` is `ovr_flag_o` AND `ovr_ie_i`.
- R9: A write strobe on `nbreq_wr_i` loads `nbreq_i` into `nbreq_o` only if `sync_en_i` and `evt_en_i` are both 0. Otherwise the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_REQ | Peripheral request lines |
| sync_i | input | NUM_SYNC | Synchronization inputs |
| req_sel_i | input | clog2(NUM_REQ) | Request line selector |
| sync_sel_i | input | clog2(NUM_SYNC) | Synchronization input selector |
| sync_en_i | input | 1 | Gate forwarding on sync edges |
| sync_pol_i | input | 2 | Edge polarity (see R6) |
| evt_en_i | input | 1 | Event generation enable |
| ovr_ie_i | input | 1 | Overrun interrupt enable |
| nbreq_wr_i | input | 1 | Write strobe for request count |
| nbreq_i | input | CNT_W | Requests per window minus one |
| ovr_clr_i | input | 1 | Write-one clear of the overrun flag |
| dma_ack_i | input | 1 | Acknowledge from DMA controller |
| dma_req_o | output | 1 | Request to DMA controller |
| evt_o | output | 1 | Event pulse after NBREQ+1 requests |
| ovr_flag_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Overrun interrupt |
| nbreq_o | output | CNT_W | Stored request count |

## Verification
The hardest case to reach is an overrun. The window must be open, and a second qualifying edge must arrive before its last handshake. Because the window also closes as soon as enough acknowledges arrive, the stimulus holds `dma_ack_i` low to keep the window open. It then toggles the sync line under both-edge polarity to produce the second edge. It also lines up a fresh edge with a clear strobe in the same cycle, to show that the set wins over the clear.

// File: rtl/srr_pkg.sv
package srr_pkg;
  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_RISE = 2'd1,
    POL_FALL = 2'd2,
    POL_BOTH = 2'd3
  } pol_e;
endpackage

// File: rtl/srr_edge_det.sv
module srr_edge_det #(
  parameter int NUM_SYNC = 32,
  localparam int SW = $clog2(NUM_SYNC)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SYNC-1:0] sync_i,
  input  logic [SW-1:0]       sel_i,
  input  logic [1:0]          pol_i,
  output logic                edge_o
);
  import srr_pkg::*;

  // whole vector registered so a selector change never fakes an edge
  logic [NUM_SYNC-1:0] sync_q;
  logic cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_i;
  end

  assign cur  = sync_i[sel_i];
  assign prev = sync_q[sel_i];

  always_comb begin
    unique case (pol_e'(pol_i))
      POL_RISE: edge_o = cur & ~prev;
      POL_FALL: edge_o = ~cur & prev;
      POL_BOTH: edge_o = cur ^ prev;
      default:  edge_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/srr_burst_ctl.sv
module srr_burst_ctl #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_en_i,
  input  logic             evt_en_i,
  input  logic             edge_i,
  input  logic             fire_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] nbreq_i,
  output logic             open_o,
  output logic             evt_o,
  output logic             ovr_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last  = (cnt_q == nbreq_i);
  assign ovr_o = sync_en_i & edge_i & open_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      open_o <= 1'b0;
      evt_o  <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      open_o <= 1'b0;
      evt_o  <= 1'b0;
    end else begin
      evt_o <= 1'b0;
      if (!sync_en_i)             open_o <= 1'b0;
      else if (edge_i && !open_o) begin
        open_o <= 1'b1;
        cnt_q  <= '0;
      end
      if (fire_i) begin
        if (last) begin
          cnt_q  <= '0;
          open_o <= 1'b0;
          evt_o  <= evt_en_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/srr_ovr_flag.sv
module srr_ovr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/sync_req_router.sv
module sync_req_router #(
  parameter int NUM_REQ  = 64,
  parameter int NUM_SYNC = 32,
  parameter int CNT_W    = 5,
  localparam int RSW = $clog2(NUM_REQ),
  localparam int SSW = $clog2(NUM_SYNC)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REQ-1:0]  req_i,
  input  logic [NUM_SYNC-1:0] sync_i,
  input  logic [RSW-1:0]      req_sel_i,
  input  logic [SSW-1:0]      sync_sel_i,
  input  logic                sync_en_i,
  input  logic [1:0]          sync_pol_i,
  input  logic                evt_en_i,
  input  logic                ovr_ie_i,
  input  logic                nbreq_wr_i,
  input  logic [CNT_W-1:0]    nbreq_i,
  input  logic                ovr_clr_i,
  input  logic                dma_ack_i,
  output logic                dma_req_o,
  output logic                evt_o,
  output logic                ovr_flag_o,
  output logic                irq_o,
  output logic [CNT_W-1:0]    nbreq_o
);
  logic sync_edge, win_open, ovr_set, fire, nb_load;

  // request count only loads while both gating features are idle
  assign nb_load = nbreq_wr_i & ~sync_en_i & ~evt_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      nbreq_o <= '0;
    else if (nb_load) nbreq_o <= nbreq_i;
  end

  srr_edge_det #(.NUM_SYNC(NUM_SYNC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .sel_i  (sync_sel_i),
    .pol_i  (sync_pol_i),
    .edge_o (sync_edge)
  );

  assign dma_req_o = req_i[req_sel_i] & (~sync_en_i | win_open);
  assign fire      = dma_req_o & dma_ack_i;

  srr_burst_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_en_i (sync_en_i),
    .evt_en_i  (evt_en_i),
    .edge_i    (sync_edge),
    .fire_i    (fire),
    .clr_i     (nb_load),
    .nbreq_i   (nbreq_o),
    .open_o    (win_open),
    .evt_o     (evt_o),
    .ovr_o     (ovr_set)
  );

  srr_ovr_flag u_ovr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovr_set),
    .clr_i  (ovr_clr_i),
    .flag_o (ovr_flag_o)
  );

  assign irq_o = ovr_flag_o & ovr_ie_i;
endmodule

// File: rtl/sync_req_router_chk.sv
module sync_req_router_chk #(
  parameter int NUM_REQ  = 64,
  parameter int CNT_W    = 5,
  localparam int RSW = $clog2(NUM_REQ)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_REQ-1:0] req_i,
  input logic [RSW-1:0]     req_sel_i,
  input logic               sync_en_i,
  input logic               evt_en_i,
  input logic               ovr_ie_i,
  input logic               ovr_clr_i,
  input logic               dma_ack_i,
  input logic               dma_req_o,
  input logic               evt_o,
  input logic               ovr_flag_o,
  input logic               irq_o,
  input logic [CNT_W-1:0]   nbreq_o
);
  p_req_source_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> req_i[req_sel_i]);

  p_evt_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(dma_req_o && dma_ack_i && evt_en_i));

  p_ovr_sync_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_flag_o) |-> $past(sync_en_i));

  p_ovr_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_flag_o && !ovr_clr_i) |=> ovr_flag_o);

  p_irq_needs_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ovr_flag_o);

  p_nbreq_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_en_i || evt_en_i) |=> $stable(nbreq_o));
endmodule

bind sync_req_router sync_req_router_chk #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_sync_req_router.sv
`timescale 1ns/100ps
module sim_sync_req_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] req_i = '0;
  logic [31:0] sync_i = '0;
  logic [5:0]  req_sel_i = '0;
  logic [4:0]  sync_sel_i = '0;
  logic        sync_en_i = 0, evt_en_i = 0, ovr_ie_i = 0, nbreq_wr_i = 0;
  logic [1:0]  sync_pol_i = '0;
  logic [4:0]  nbreq_i = '0;
  logic        ovr_clr_i = 0, dma_ack_i = 0;
  logic        dma_req_o, evt_o, ovr_flag_o, irq_o;
  logic [4:0]  nbreq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  sync_req_router u0 (.*);

  function automatic logic exp_pass(logic [63:0] r, logic [5:0] s);
    return r[s];
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  // count forwarded-request cycles and event pulses over a window
  task automatic window(input int len, output int nreq, output int nevt);
    nreq = 0; nevt = 0;
    for (int k = 0; k < len; k++) begin
      tick();
      nreq += int'(dma_req_o);
      nevt += int'(evt_o);
    end
  endtask

  task automatic wr_nbreq(input logic [4:0] v);
    nbreq_i = v; nbreq_wr_i = 1; tick(); nbreq_wr_i = 0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, e;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1; #1;
    chk("R1 dma_req", dma_req_o, 0);
    chk("R1 evt", evt_o, 0);
    chk("R1 ovr", ovr_flag_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 nbreq", nbreq_o, 0);

    // R2: pass-through with random sync activity
    for (int i = 0; i < 40; i++) begin
      req_i      = {$urandom, $urandom};
      req_sel_i  = 6'($urandom % 64);
      sync_i     = $urandom;
      sync_sel_i = 5'($urandom % 32);
      sync_pol_i = 2'($urandom % 4);
      #1 chk("R2 pass", dma_req_o, exp_pass(req_i, req_sel_i));
      tick();
    end
    sync_i = '0; req_i = '0; tick(); tick();

    // R9: count write gating
    wr_nbreq(5'd3); chk("R9 accepted", nbreq_o, 3);
    sync_en_i = 1; wr_nbreq(5'd9); chk("R9 ignored sync_en", nbreq_o, 3);
    sync_en_i = 0; evt_en_i = 1; wr_nbreq(5'd9); chk("R9 ignored evt_en", nbreq_o, 3);

    // R3/R4/R5: rising edge releases a window of NBREQ+1
    req_sel_i = 6'd10; req_i = 64'd1 << 10; sync_sel_i = 5'd7;
    sync_pol_i = 2'd1; sync_en_i = 1; dma_ack_i = 1;
    tick(); tick();
    chk("R3 gated before edge", dma_req_o, 0);
    sync_i[7] = 1; #1;
    chk("R3 gated same cycle as edge", dma_req_o, 0);
    window(10, n, e);
    chk("R4 window length", n, 4);
    chk("R5 one event pulse", e, 1);

    // R6: polarity encodings, sync_i[7] currently 1
    sync_pol_i = 2'd2; sync_i[7] = 0; window(10, n, e);
    chk("R6 falling opens", n, 4);
    sync_i[7] = 1; window(10, n, e);
    chk("R6 rising ignored under falling", n, 0);
    sync_pol_i = 2'd0; sync_i[7] = 0; window(10, n, e);
    chk("R6 none ignores edge", n, 0);
    sync_pol_i = 2'd3; sync_i[7] = 1; window(10, n, e);
    chk("R6 both opens", n, 4);

    // R7/R8: overrun with ack held low
    evt_en_i = 0; dma_ack_i = 0;
    sync_i[7] = 0; tick(); tick();
    chk("R7 no flag on first edge", ovr_flag_o, 0);
    sync_i[7] = 1; tick();
    chk("R7 overrun set", ovr_flag_o, 1);
    chk("R8 irq masked", irq_o, 0);
    chk("R7 window keeps forwarding", dma_req_o, 1);
    ovr_ie_i = 1; #1;
    chk("R8 irq enabled", irq_o, 1);
    repeat (5) tick();
    chk("R8 flag sticky", ovr_flag_o, 1);
    ovr_clr_i = 1; tick(); ovr_clr_i = 0;
    chk("R8 cleared", ovr_flag_o, 0);
    chk("R8 irq dropped", irq_o, 0);
    sync_i[7] = 0; ovr_clr_i = 1; tick(); ovr_clr_i = 0;
    chk("R8 set wins over clear", ovr_flag_o, 1);
    ovr_clr_i = 1; tick(); ovr_clr_i = 0;

    // R5 in pass-through mode with NBREQ=1
    sync_en_i = 0; tick();
    wr_nbreq(5'd1);
    chk("R9 second write", nbreq_o, 1);
    evt_en_i = 1; dma_ack_i = 1;
    window(6, n, e);
    chk("R5 events without sync", e, 3);
    chk("R2 pass held", n, 6);
    chk("R7 no flag in pass mode", ovr_flag_o, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule